// File: doc/BRIEF.md
# In-Order Retirement Buffer with Micro-Op Entry Accounting

This block keeps in-flight instructions in program order between dispatch and retirement. Each dispatched instruction takes a contiguous run of buffer slots, one slot per micro-op. The block hands back the index of the first slot, and the execution side later quotes that index on a write-back strobe to mark the instruction complete. Completed instructions leave from the head, oldest first and never out of order, with up to `RET_W` instructions per cycle. For each instruction that retires and owns a destination, the block presents its physical register tag on a release lane so the rename logic can free it.

Dispatch is told at once whether a request fits. The free-slot count is taken at the start of the cycle. A request that does not fit is refused and raises a dedicated stall flag naming slot shortage as the cause. A three-state machine tracks fill level, with states `RB_EMPTY`, `RB_PARTIAL` and `RB_FULL`. It drives the empty and full flags. Its transitions are:
- fill: out of `RB_EMPTY`.
- top-off: into `RB_FULL`.
- drain: into `RB_EMPTY`.
- hold: staying in the same state.
- relieve: `RB_FULL` to `RB_PARTIAL`.

Top module: `rob_retire_unit`

## Requirements
- R1: After reset the occupancy is 0, the free count equals DEPTH, the empty flag is 1 and the full flag is 0, the retire count is 0, and the next dispatch index is 0.
- R2: A request with micro-op count n (1..MAX_UOPS) is accepted in the same cycle when n does not exceed the free count. It then occupies n slots, and `disp_idx` shows the index of its first slot.
- R3: A request with a micro-op count of 0 is never accepted, takes no slots and raises no stall.
- R4: `disp_stall_full` is 1 exactly when a request with nonzero count is presented and its count exceeds the free count.
- R5: A write-back strobe naming an instruction's first-slot index marks it complete. That instruction can retire no earlier than the cycle after the strobe.
- R6: A completed instruction does not retire while any older instruction is still incomplete.
- R7: Each cycle, `ret_count` equals the number of leading completed instructions at the head, capped at RET_W.
- R8: Release lane k is valid exactly when the k-th retiring instruction has a destination. In that case it carries the register tag given at its dispatch, in field bits [k*PREG_W +: PREG_W].
- R9: At each clock edge the occupancy grows by the accepted micro-op count and shrinks by the micro-op counts of the instructions retiring in that cycle. `free_entries` is always DEPTH minus `occupancy`.
- R10: Slot indices wrap modulo DEPTH. Each new instruction's index is the previous index plus the previous micro-op count, modulo DEPTH.
- R11: `rob_empty` is 1 exactly when occupancy is 0. `rob_full` is 1 exactly when occupancy equals DEPTH.
- R12: Slots freed by retirement in a cycle cannot be used by a dispatch in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request present |
| disp_uops | input | $clog2(MAX_UOPS+1) | Micro-op count of the request |
| disp_preg | input | PREG_W | Destination physical register tag |
| disp_has_dest | input | 1 | Request owns a destination register |
| disp_accept | output | 1 | Request taken this cycle |
| disp_stall_full | output | 1 | Request refused for lack of slots |
| disp_idx | output | $clog2(DEPTH) | First-slot index given to the request |
| wb_valid | input | 1 | Write-back strobe |
| wb_idx | input | $clog2(DEPTH) | First-slot index of the completing instruction |
| ret_count | output | $clog2(RET_W+1) | Instructions retiring this cycle |
| rel_valid | output | RET_W | Per-lane register release strobe |
| rel_preg | output | RET_W*PREG_W | Per-lane released register tags |
| free_entries | output | $clog2(DEPTH+1) | Free slots at start of cycle |
| occupancy | output | $clog2(DEPTH+1) | Used slots at start of cycle |
| rob_empty | output | 1 | No slot in use |
| rob_full | output | 1 | All slots in use |

## Verification
A wrong head pointer or a bad slot-count sum shows up within one cycle. The release lanes then present the wrong tag, or the occupancy is off by a micro-op count, and the free count and the acceptance of the next request follow from that. A completion flag set on the wrong slot shows as a retirement in the cycle after the strobe that should not happen, or as a retirement that never comes. A tail that does not wrap correctly gives a mismatched `disp_idx` on the first request after the boundary. The reference model compares every one of these outputs on every cycle, so a fault is flagged in the first cycle it reaches a port.

// File: rtl/rob_pkg.sv
package rob_pkg;
    typedef enum logic [1:0] {
        RB_EMPTY   = 2'd0,
        RB_PARTIAL = 2'd1,
        RB_FULL    = 2'd2
    } rob_state_e;
endpackage

// File: rtl/rob_alloc_ctrl.sv
module rob_alloc_ctrl
    import rob_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int UOP_W = 3,
    parameter int IDX_W = 4,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [UOP_W-1:0] req_uops,
    input  logic [CNT_W-1:0] ret_uops,
    output logic [IDX_W-1:0] head_o,
    output logic [IDX_W-1:0] tail_o,
    output logic [CNT_W-1:0] occ_o,
    output logic [CNT_W-1:0] free_o,
    output logic             accept_o,
    output logic             stall_o,
    output logic             empty_o,
    output logic             full_o
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    rob_state_e       state_q, state_d;
    logic [IDX_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] occ_q, occ_d, req_n;
    logic             nonzero;

    assign req_n    = CNT_W'(req_uops);
    assign nonzero  = (req_uops != '0);
    assign free_o   = DEPTH_C - occ_q;
    assign accept_o = req_valid && nonzero && (req_n <= free_o);
    assign stall_o  = req_valid && nonzero && (req_n > free_o);
    assign occ_d    = occ_q + (accept_o ? req_n : '0) - ret_uops;
    assign head_o   = head_q;
    assign tail_o   = tail_q;
    assign occ_o    = occ_q;

    function automatic rob_state_e level_of(input logic [CNT_W-1:0] occ);
        if (occ == '0)
            return RB_EMPTY;
        else if (occ == DEPTH_C)
            return RB_FULL;
        else
            return RB_PARTIAL;
    endfunction

    // next-state: fill, top-off, drain, relieve or hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RB_EMPTY:   state_d = level_of(occ_d);
            RB_PARTIAL: state_d = level_of(occ_d);
            RB_FULL:    state_d = level_of(occ_d);
            default:    state_d = RB_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RB_EMPTY;
            head_q  <= '0;
            tail_q  <= '0;
            occ_q   <= '0;
        end else begin
            state_q <= state_d;
            head_q  <= head_q + IDX_W'(ret_uops);
            tail_q  <= tail_q + (accept_o ? IDX_W'(req_uops) : '0);
            occ_q   <= occ_d;
        end
    end

    always_comb begin
        empty_o = 1'b0;
        full_o  = 1'b0;
        unique case (state_q)
            RB_EMPTY:   empty_o = 1'b1;
            RB_PARTIAL: ;
            RB_FULL:    full_o  = 1'b1;
            default:    empty_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/rob_entry_store.sv
module rob_entry_store #(
    parameter int DEPTH  = 16,
    parameter int UOP_W  = 3,
    parameter int IDX_W  = 4,
    parameter int PREG_W = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         alloc,
    input  logic [IDX_W-1:0]             alloc_idx,
    input  logic [UOP_W-1:0]             alloc_uops,
    input  logic [PREG_W-1:0]            alloc_preg,
    input  logic                         alloc_dest,
    input  logic                         wb_valid,
    input  logic [IDX_W-1:0]             wb_idx,
    output logic [DEPTH-1:0][UOP_W-1:0]  uops_o,
    output logic [DEPTH-1:0][PREG_W-1:0] preg_o,
    output logic [DEPTH-1:0]             dest_o,
    output logic [DEPTH-1:0]             done_o
);
    logic [DEPTH-1:0][UOP_W-1:0]  uops_q;
    logic [DEPTH-1:0][PREG_W-1:0] preg_q;
    logic [DEPTH-1:0]             dest_q;
    logic [DEPTH-1:0]             done_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic hit_alloc, hit_wb;
        assign hit_alloc = alloc && (alloc_idx == IDX_W'(i));
        assign hit_wb    = wb_valid && (wb_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                uops_q[i] <= '0;
                preg_q[i] <= '0;
                dest_q[i] <= 1'b0;
                done_q[i] <= 1'b0;
            end else if (hit_alloc) begin
                uops_q[i] <= alloc_uops;
                preg_q[i] <= alloc_preg;
                dest_q[i] <= alloc_dest;
                done_q[i] <= 1'b0;
            end else if (hit_wb) begin
                done_q[i] <= 1'b1;
            end
        end
    end

    assign uops_o = uops_q;
    assign preg_o = preg_q;
    assign dest_o = dest_q;
    assign done_o = done_q;
endmodule

// File: rtl/rob_retire_pick.sv
module rob_retire_pick #(
    parameter int DEPTH  = 16,
    parameter int UOP_W  = 3,
    parameter int IDX_W  = 4,
    parameter int PREG_W = 6,
    parameter int CNT_W  = 5,
    parameter int RET_W  = 2,
    parameter int OFF_W  = 6,
    parameter int RC_W   = 2
) (
    input  logic [IDX_W-1:0]             head,
    input  logic [CNT_W-1:0]             occ,
    input  logic [DEPTH-1:0][UOP_W-1:0]  uops,
    input  logic [DEPTH-1:0][PREG_W-1:0] preg,
    input  logic [DEPTH-1:0]             dest,
    input  logic [DEPTH-1:0]             done,
    output logic [RC_W-1:0]              ret_count,
    output logic [CNT_W-1:0]             ret_uops,
    output logic [RET_W-1:0]             rel_valid,
    output logic [RET_W*PREG_W-1:0]      rel_preg
);
    logic             go  [RET_W+1];
    logic [OFF_W-1:0] off [RET_W+1];
    logic [RET_W-1:0] take;

    assign go[0]  = 1'b1;
    assign off[0] = '0;

    for (genvar k = 0; k < RET_W; k++) begin : g_lane
        logic [IDX_W-1:0] pos;
        logic             live;
        assign pos      = head + IDX_W'(off[k]);
        assign live     = off[k] < OFF_W'(occ);
        assign go[k+1]  = go[k] && live && done[pos];
        assign off[k+1] = off[k] + (go[k+1] ? OFF_W'(uops[pos]) : '0);
        assign take[k]  = go[k+1];
        assign rel_valid[k] = go[k+1] && dest[pos];
        assign rel_preg[k*PREG_W +: PREG_W] = preg[pos];
    end

    always_comb begin
        ret_count = '0;
        for (int k = 0; k < RET_W; k++)
            ret_count = ret_count + RC_W'(take[k]);
    end

    assign ret_uops = CNT_W'(off[RET_W]);
endmodule

// File: rtl/rob_retire_unit.sv
module rob_retire_unit #(
    parameter int DEPTH    = 16,
    parameter int MAX_UOPS = 4,
    parameter int RET_W    = 2,
    parameter int PREG_W   = 6,
    localparam int UOP_W   = $clog2(MAX_UOPS + 1),
    localparam int IDX_W   = $clog2(DEPTH),
    localparam int CNT_W   = $clog2(DEPTH + 1),
    localparam int RC_W    = $clog2(RET_W + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    disp_valid,
    input  logic [UOP_W-1:0]        disp_uops,
    input  logic [PREG_W-1:0]       disp_preg,
    input  logic                    disp_has_dest,
    output logic                    disp_accept,
    output logic                    disp_stall_full,
    output logic [IDX_W-1:0]        disp_idx,
    input  logic                    wb_valid,
    input  logic [IDX_W-1:0]        wb_idx,
    output logic [RC_W-1:0]         ret_count,
    output logic [RET_W-1:0]        rel_valid,
    output logic [RET_W*PREG_W-1:0] rel_preg,
    output logic [CNT_W-1:0]        free_entries,
    output logic [CNT_W-1:0]        occupancy,
    output logic                    rob_empty,
    output logic                    rob_full
);
    localparam int OFF_W = $clog2(DEPTH + MAX_UOPS + 1);

    logic [IDX_W-1:0]             head;
    logic [CNT_W-1:0]             ret_uops;
    logic [DEPTH-1:0][UOP_W-1:0]  s_uops;
    logic [DEPTH-1:0][PREG_W-1:0] s_preg;
    logic [DEPTH-1:0]             s_dest;
    logic [DEPTH-1:0]             s_done;

    rob_alloc_ctrl #(
        .DEPTH(DEPTH), .UOP_W(UOP_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_alloc (
        .clk(clk), .rst_n(rst_n),
        .req_valid(disp_valid), .req_uops(disp_uops), .ret_uops(ret_uops),
        .head_o(head), .tail_o(disp_idx), .occ_o(occupancy), .free_o(free_entries),
        .accept_o(disp_accept), .stall_o(disp_stall_full),
        .empty_o(rob_empty), .full_o(rob_full)
    );

    rob_entry_store #(
        .DEPTH(DEPTH), .UOP_W(UOP_W), .IDX_W(IDX_W), .PREG_W(PREG_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .alloc(disp_accept), .alloc_idx(disp_idx), .alloc_uops(disp_uops),
        .alloc_preg(disp_preg), .alloc_dest(disp_has_dest),
        .wb_valid(wb_valid), .wb_idx(wb_idx),
        .uops_o(s_uops), .preg_o(s_preg), .dest_o(s_dest), .done_o(s_done)
    );

    rob_retire_pick #(
        .DEPTH(DEPTH), .UOP_W(UOP_W), .IDX_W(IDX_W), .PREG_W(PREG_W),
        .CNT_W(CNT_W), .RET_W(RET_W), .OFF_W(OFF_W), .RC_W(RC_W)
    ) u_pick (
        .head(head), .occ(occupancy),
        .uops(s_uops), .preg(s_preg), .dest(s_dest), .done(s_done),
        .ret_count(ret_count), .ret_uops(ret_uops),
        .rel_valid(rel_valid), .rel_preg(rel_preg)
    );
endmodule

// File: rtl/rob_retire_checker.sv
module rob_retire_checker #(
    parameter int DEPTH = 16,
    parameter int RET_W = 2,
    parameter int UOP_W = 3,
    parameter int IDX_W = 4,
    parameter int CNT_W = 5,
    parameter int RC_W  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             disp_accept,
    input logic             disp_stall_full,
    input logic [UOP_W-1:0] disp_uops,
    input logic [IDX_W-1:0] disp_idx,
    input logic [RC_W-1:0]  ret_count,
    input logic [RET_W-1:0] rel_valid,
    input logic [CNT_W-1:0] free_entries,
    input logic [CNT_W-1:0] occupancy,
    input logic             rob_empty,
    input logic             rob_full
);
    AST_OCC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= CNT_W'(DEPTH)); // R9
    AST_FREE_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(free_entries) + 32'(occupancy)) == DEPTH); // R9
    AST_ACCEPT_XOR_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !(disp_accept && disp_stall_full)); // R4
    AST_RET_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        32'(ret_count) <= RET_W); // R7
    AST_EMPTY_NO_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        rob_empty |-> ret_count == '0); // R11
    AST_RELEASE_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rel_valid) <= 32'(ret_count)); // R8
    AST_FULL_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        rob_full |-> !disp_accept); // R12
    AST_IDLE_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_accept |=> occupancy <= $past(occupancy)); // R9
    AST_TAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        disp_accept |=> disp_idx == IDX_W'($past(disp_idx) + IDX_W'($past(disp_uops)))); // R10
endmodule

bind rob_retire_unit rob_retire_checker #(
    .DEPTH(DEPTH), .RET_W(RET_W), .UOP_W(UOP_W),
    .IDX_W(IDX_W), .CNT_W(CNT_W), .RC_W(RC_W)
) u_checker (
    .clk(clk), .rst_n(rst_n),
    .disp_accept(disp_accept), .disp_stall_full(disp_stall_full),
    .disp_uops(disp_uops), .disp_idx(disp_idx),
    .ret_count(ret_count), .rel_valid(rel_valid),
    .free_entries(free_entries), .occupancy(occupancy),
    .rob_empty(rob_empty), .rob_full(rob_full)
);

// File: tb/rob_retire_unit_test.sv
module rob_retire_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 16;
    localparam int MAXU   = 4;
    localparam int RET_W  = 2;
    localparam int PREG_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic disp_valid = 1'b0;
    logic [2:0] disp_uops = '0;
    logic [PREG_W-1:0] disp_preg = '0;
    logic disp_has_dest = 1'b0;
    logic disp_accept, disp_stall_full;
    logic [3:0] disp_idx;
    logic wb_valid = 1'b0;
    logic [3:0] wb_idx = '0;
    logic [1:0] ret_count;
    logic [RET_W-1:0] rel_valid;
    logic [RET_W*PREG_W-1:0] rel_preg;
    logic [4:0] free_entries, occupancy;
    logic rob_empty, rob_full;

    rob_retire_unit #(.DEPTH(DEPTH), .MAX_UOPS(MAXU), .RET_W(RET_W), .PREG_W(PREG_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_uops(disp_uops), .disp_preg(disp_preg),
        .disp_has_dest(disp_has_dest), .disp_accept(disp_accept),
        .disp_stall_full(disp_stall_full), .disp_idx(disp_idx),
        .wb_valid(wb_valid), .wb_idx(wb_idx),
        .ret_count(ret_count), .rel_valid(rel_valid), .rel_preg(rel_preg),
        .free_entries(free_entries), .occupancy(occupancy),
        .rob_empty(rob_empty), .rob_full(rob_full)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    // reference model: in-flight instructions, oldest first
    int q_idx[$], q_uops[$], q_preg[$], q_dest[$], q_done[$];
    int m_occ = 0;
    int m_tail = 0;
    int obs_ret, obs_acc, obs_stall;

    task automatic chk(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int pick_wb();
        int cand[$];
        for (int i = 0; i < q_idx.size(); i++)
            if (q_done[i] == 0) cand.push_back(i);
        if (cand.size() == 0) return -1;
        return cand[$urandom % cand.size()];
    endfunction

    task automatic cyc(input bit v, input int u, input int p, input bit d,
                       input bit wv, input int wi);
        int exp_free, n, retu;
        bit exp_acc;
        @(negedge clk);
        disp_valid = v; disp_uops = 3'(u); disp_preg = PREG_W'(p);
        disp_has_dest = d; wb_valid = wv; wb_idx = 4'(wi);
        #1;
        exp_free = DEPTH - m_occ;
        exp_acc = v && (u != 0) && (u <= exp_free);
        n = 0;
        while (n < RET_W && n < q_idx.size() && q_done[n] != 0) n++;
        chk("R9 occupancy", int'(occupancy), m_occ);
        chk("R9 free", int'(free_entries), exp_free);
        chk("R2 accept", int'(disp_accept), int'(exp_acc));
        chk("R4 stall", int'(disp_stall_full), int'(v && u != 0 && u > exp_free));
        chk("R10 index", int'(disp_idx), m_tail);
        chk("R7 retire count", int'(ret_count), n);
        chk("R11 empty", int'(rob_empty), int'(m_occ == 0));
        chk("R11 full", int'(rob_full), int'(m_occ == DEPTH));
        for (int k = 0; k < RET_W; k++) begin
            bit ev;
            ev = (k < n) && (q_dest[k] != 0);
            chk("R8 release valid", int'(rel_valid[k]), int'(ev));
            if (ev)
                chk("R8 release tag", int'(rel_preg[k*PREG_W +: PREG_W]), q_preg[k]);
        end
        obs_ret = int'(ret_count); obs_acc = int'(disp_accept); obs_stall = int'(disp_stall_full);
        @(posedge clk);
        if (wv)
            for (int i = 0; i < q_idx.size(); i++)
                if (q_idx[i] == wi) q_done[i] = 1;
        retu = 0;
        for (int i = 0; i < n; i++) begin
            retu += q_uops[0];
            void'(q_idx.pop_front()); void'(q_uops.pop_front());
            void'(q_preg.pop_front()); void'(q_dest.pop_front());
            void'(q_done.pop_front());
        end
        if (exp_acc) begin
            q_idx.push_back(m_tail); q_uops.push_back(u);
            q_preg.push_back(p); q_dest.push_back(int'(d)); q_done.push_back(0);
            m_tail = (m_tail + u) % DEPTH;
        end
        m_occ = m_occ + (exp_acc ? u : 0) - retu;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int w;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R1 occupancy", int'(occupancy), 0);
        chk("R1 free", int'(free_entries), DEPTH);
        chk("R1 empty", int'(rob_empty), 1);
        chk("R1 full", int'(rob_full), 0);
        chk("R1 retire", int'(ret_count), 0);
        chk("R1 index", int'(disp_idx), 0);

        // fill with four 4-uop instructions
        for (int i = 0; i < 4; i++) cyc(1, 4, 10 + i, 1, 0, 0);
        cyc(1, 1, 20, 1, 0, 0);
        chk("R4 stall when full", obs_stall, 1);
        chk("R11 full flag", int'(rob_full), 1);

        // youngest completes first: nothing may retire
        cyc(0, 0, 0, 0, 1, 12);
        chk("R5 no retire in write-back cycle", obs_ret, 0);
        cyc(0, 0, 0, 0, 0, 0);
        chk("R6 younger done waits for older", obs_ret, 0);

        // oldest completes; retires next cycle while a dispatch is refused
        cyc(0, 0, 0, 0, 1, 0);
        chk("R5 oldest not yet retiring", obs_ret, 0);
        cyc(1, 1, 21, 1, 0, 0);
        chk("R7 oldest retires", obs_ret, 1);
        chk("R12 freed slots not reused same cycle", obs_acc, 0);
        cyc(1, 1, 22, 0, 0, 0);
        chk("R2 accepted after release", obs_acc, 1);

        cyc(1, 0, 23, 1, 0, 0);
        chk("R3 zero count not accepted", obs_acc, 0);
        chk("R3 zero count no stall", obs_stall, 0);

        // random traffic with wrap-around
        for (int c = 0; c < 3000; c++) begin
            w = ($urandom % 4 != 0) ? pick_wb() : -1;
            cyc($urandom % 3 != 0, 1 + $urandom % MAXU, $urandom % 64,
                $urandom % 4 != 0, w >= 0, (w >= 0) ? q_idx[w] : 0);
        end

        // drain
        for (int c = 0; c < 200 && q_idx.size() > 0; c++) begin
            w = pick_wb();
            cyc(0, 0, 0, 0, w >= 0, (w >= 0) ? q_idx[w] : 0);
        end
        cyc(0, 0, 0, 0, 0, 0);
        chk("R11 empty after drain", int'(rob_empty), 1);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule